// File: doc/BRIEF.md
# Pixel FIFO Panic Priority Monitor

This block watches how full the pixel-fetch FIFO of a display pipeline is and raises a priority-boost signal toward the memory interconnect when the FIFO runs low, so that the fetch engine is served ahead of other traffic before the display starves. The boost has hysteresis between two watermarks. It sets when the fill level drops under the low watermark. It stays set until the level climbs above the high watermark. The boost only steers arbitration and never raises an interrupt. It is forced off whenever the panic enable is cleared or the display is idle.

The same block also tells the fetch engine when to ask for more data. A burst-size code selects 128-byte or 256-byte fetches. A request is raised only when the FIFO has room for a whole burst. A sticky underrun flag records any read of the FIFO while it is empty, and it stays set until it is cleared explicitly. The watermarks are either taken from the threshold inputs or from built-in defaults at one third and two thirds of the FIFO depth. The FIFO storage and the memory bus protocol sit outside this block.

All levels and thresholds count FIFO words of `WORD_BYTES` bytes. With the default parameters the FIFO holds 64 words of 8 bytes.

Top module: `pixfifo_panic_mon`

## Requirements
- R1: With `panic_en`=1 and `disp_active`=1, a fill level strictly below the effective low watermark drives `prio_boost` to 1 on the next clock edge.
- R2: While enabled and active, with the level not below the low watermark, `prio_boost` clears on the next edge only if the level is strictly above the effective high watermark. Otherwise it keeps its previous value.
- R3: `disp_active`=0 forces `prio_boost` to 0 on the next edge. After the display becomes active again, the boost stays 0 until R1 sets it.
- R4: `panic_en`=0 forces `prio_boost` to 0 on the next edge, whatever the level is.
- R5: With `use_dflt_thr`=1 the effective watermarks are floor(D/3) and floor(2D/3), where D is the FIFO depth in words (21 and 42 by default), and `thr_low` and `thr_high` have no effect. With `use_dflt_thr`=0 the effective watermarks are `thr_low` and `thr_high`.
- R6: `fetch_len` shows on the next edge the burst length in words for `burst_code`. Code 1 gives 128/WORD_BYTES words (16 by default). Code 2 gives 256/WORD_BYTES words (32 by default). Codes 0 and 3 give 0.
- R7: `fetch_req` is 1 on the next edge exactly when `disp_active`=1, the code gives a non-zero length, and level + length <= D. Codes 0 and 3 never request.
- R8: `underrun` is set on the next edge when `fifo_rd`=1 while `fifo_level`=0. It then stays set until `urun_clr`=1, which clears it on the next edge. If a set and a clear occur in the same cycle, the set wins.
- R9: A synchronous active-high `rst` drives `prio_boost`, `fetch_req`, `fetch_len` and `underrun` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| panic_en | input | 1 | Enables the priority booster |
| disp_active | input | 1 | Display is scanning out |
| use_dflt_thr | input | 1 | Selects the built-in watermarks |
| thr_low | input | 7 | Programmed low watermark in words |
| thr_high | input | 7 | Programmed high watermark in words |
| fifo_level | input | 7 | Current FIFO fill level in words |
| fifo_rd | input | 1 | Display read strobe on the FIFO |
| burst_code | input | 2 | Fetch size code (1 = 128 B, 2 = 256 B) |
| urun_clr | input | 1 | Clears the underrun flag |
| prio_boost | output | 1 | Priority boost toward the interconnect |
| fetch_req | output | 1 | The FIFO has room for one burst |
| fetch_len | output | 7 | Burst length in words |
| underrun | output | 1 | Sticky empty-read flag |

## Verification
The inline properties check the following on every cycle: the forced-off paths of the boost (display idle, enable cleared), the set on a low level, the hold inside the hysteresis band, the rule that reserved codes, an idle display or a missing burst of room never produce a request, and the set, hold and clear of the underrun flag. Some behaviour can only be shown by the bench's sweeps. These include the exact switching points at the watermark boundaries as the level ramps down and back up, the default watermark values with conflicting programmed inputs, and the exact burst lengths against every level for each code.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [1:0] {
    BURST_OFF  = 2'd0,
    BURST_128B = 2'd1,
    BURST_256B = 2'd2,
    BURST_RSVD = 2'd3
  } burst_code_e;

  function automatic int burst_bytes(input int code);
    case (code)
      1:       burst_bytes = 128;
      2:       burst_bytes = 256;
      default: burst_bytes = 0;
    endcase
  endfunction
endpackage

// File: rtl/fpm_thresh_sel.sv
module fpm_thresh_sel #(
  parameter int THR_MAX = 64,
  parameter int LVL_W   = 7
) (
  input  logic             use_dflt,
  input  logic [LVL_W-1:0] low_prog,
  input  logic [LVL_W-1:0] high_prog,
  output logic [LVL_W-1:0] low_eff,
  output logic [LVL_W-1:0] high_eff
);
  localparam int DFLT_LOW  = THR_MAX / 3;
  localparam int DFLT_HIGH = (2 * THR_MAX) / 3;

  always_comb begin
    if (use_dflt) begin
      low_eff  = LVL_W'(DFLT_LOW);
      high_eff = LVL_W'(DFLT_HIGH);
    end else begin
      low_eff  = low_prog;
      high_eff = high_prog;
    end
  end
endmodule

// File: rtl/fpm_boost_ctrl.sv
module fpm_boost_ctrl #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             panic_en,
  input  logic             disp_active,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] low_wm,
  input  logic [LVL_W-1:0] high_wm,
  output logic             boost
);
  logic armed;
  assign armed = panic_en && disp_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      boost <= 1'b0;
    end else if (!armed) begin
      boost <= 1'b0;
    end else if (level < low_wm) begin
      boost <= 1'b1;
    end else if (level > high_wm) begin
      boost <= 1'b0;
    end
  end

  a_r1_set_when_low: assert property (@(posedge clk) disable iff (rst)
    (armed && level < low_wm) |=> boost);
  a_r2_hold_in_band: assert property (@(posedge clk) disable iff (rst)
    (armed && boost && level <= high_wm) |=> boost);
  a_r2_no_set_above_low: assert property (@(posedge clk) disable iff (rst)
    (!boost && level >= low_wm) |=> !boost);
  a_r3_idle_display_off: assert property (@(posedge clk) disable iff (rst)
    !disp_active |=> !boost);
  a_r4_disable_off: assert property (@(posedge clk) disable iff (rst)
    !panic_en |=> !boost);
endmodule

// File: rtl/fpm_fetch_gen.sv
module fpm_fetch_gen #(
  parameter int FIFO_WORDS = 64,
  parameter int WORD_BYTES = 8,
  parameter int LVL_W      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disp_active,
  input  logic [LVL_W-1:0] level,
  input  logic [1:0]       burst_code,
  output logic             fetch_req,
  output logic [LVL_W-1:0] fetch_len
);
  import fpm_pkg::*;

  localparam int SW     = LVL_W + 1;
  localparam int NCODES = 4;

  logic [LVL_W-1:0] len_tbl [NCODES];
  logic [LVL_W-1:0] len_sel;
  logic [SW-1:0]    need;
  logic             room_ok;

  for (genvar c = 0; c < NCODES; c++) begin : g_len
    localparam int BYTES = burst_bytes(c);
    assign len_tbl[c] = LVL_W'(BYTES / WORD_BYTES);
  end

  assign len_sel = len_tbl[burst_code];
  assign need    = {1'b0, level} + {1'b0, len_sel};
  assign room_ok = need <= SW'(FIFO_WORDS);

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_req <= 1'b0;
      fetch_len <= '0;
    end else begin
      fetch_req <= disp_active && (len_sel != '0) && room_ok;
      fetch_len <= len_sel;
    end
  end

  a_r7_rsvd_no_req: assert property (@(posedge clk) disable iff (rst)
    (burst_code == BURST_OFF || burst_code == BURST_RSVD) |=> !fetch_req);
  a_r7_idle_no_req: assert property (@(posedge clk) disable iff (rst)
    !disp_active |=> !fetch_req);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, level} + {1'b0, len_sel} > SW'(FIFO_WORDS)) |=> !fetch_req);
  a_r6_req_has_len: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> fetch_len != '0);
endmodule

// File: rtl/fpm_underrun.sv
module fpm_underrun #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic [LVL_W-1:0] level,
  input  logic             clr,
  output logic             flag
);
  logic empty_rd;
  assign empty_rd = rd && (level == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (empty_rd) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  a_r8_set_on_empty_read: assert property (@(posedge clk) disable iff (rst)
    empty_rd |=> flag);
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !empty_rd) |=> !flag);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!flag && !empty_rd) |=> !flag);
endmodule

// File: rtl/pixfifo_panic_mon.sv
module pixfifo_panic_mon #(
  parameter int FIFO_WORDS = 64,
  parameter int WORD_BYTES = 8,
  parameter int LVL_W      = $clog2(FIFO_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             panic_en,
  input  logic             disp_active,
  input  logic             use_dflt_thr,
  input  logic [LVL_W-1:0] thr_low,
  input  logic [LVL_W-1:0] thr_high,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_rd,
  input  logic [1:0]       burst_code,
  input  logic             urun_clr,
  output logic             prio_boost,
  output logic             fetch_req,
  output logic [LVL_W-1:0] fetch_len,
  output logic             underrun
);
  logic [LVL_W-1:0] low_eff;
  logic [LVL_W-1:0] high_eff;

  fpm_thresh_sel #(.THR_MAX(FIFO_WORDS), .LVL_W(LVL_W)) u_thr (
    .use_dflt (use_dflt_thr),
    .low_prog (thr_low),
    .high_prog(thr_high),
    .low_eff  (low_eff),
    .high_eff (high_eff)
  );

  fpm_boost_ctrl #(.LVL_W(LVL_W)) u_boost (
    .clk        (clk),
    .rst        (rst),
    .panic_en   (panic_en),
    .disp_active(disp_active),
    .level      (fifo_level),
    .low_wm     (low_eff),
    .high_wm    (high_eff),
    .boost      (prio_boost)
  );

  fpm_fetch_gen #(.FIFO_WORDS(FIFO_WORDS), .WORD_BYTES(WORD_BYTES), .LVL_W(LVL_W)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .disp_active(disp_active),
    .level      (fifo_level),
    .burst_code (burst_code),
    .fetch_req  (fetch_req),
    .fetch_len  (fetch_len)
  );

  fpm_underrun #(.LVL_W(LVL_W)) u_urun (
    .clk  (clk),
    .rst  (rst),
    .rd   (fifo_rd),
    .level(fifo_level),
    .clr  (urun_clr),
    .flag (underrun)
  );

  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!prio_boost && !fetch_req && !underrun && fetch_len == '0));
endmodule

// File: tb/pixfifo_panic_mon_tb.sv
`timescale 1ns/1ps
module pixfifo_panic_mon_tb;
  localparam int D  = 64;
  localparam int WB = 8;
  localparam int LW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic panic_en = 1'b0, disp_active = 1'b0, use_dflt_thr = 1'b0;
  logic [LW-1:0] thr_low = '0, thr_high = '0, fifo_level = '0;
  logic fifo_rd = 1'b0, urun_clr = 1'b0;
  logic [1:0] burst_code = 2'd0;
  logic prio_boost, fetch_req, underrun;
  logic [LW-1:0] fetch_len;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string btag = "R2";

  int m_boost = 0, m_req = 0, m_len = 0, m_ur = 0;

  always #5 clk = ~clk;

  pixfifo_panic_mon #(.FIFO_WORDS(D), .WORD_BYTES(WB)) u_dut (
    .clk(clk), .rst(rst), .panic_en(panic_en), .disp_active(disp_active),
    .use_dflt_thr(use_dflt_thr), .thr_low(thr_low), .thr_high(thr_high),
    .fifo_level(fifo_level), .fifo_rd(fifo_rd), .burst_code(burst_code),
    .urun_clr(urun_clr), .prio_boost(prio_boost), .fetch_req(fetch_req),
    .fetch_len(fetch_len), .underrun(underrun)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d level=%0d code=%0d t=%0t",
               tag, act, exp, fifo_level, burst_code, $time);
    end
  endtask

  // Reference model from the requirements, evaluated on the held inputs.
  task automatic model();
    int lo, hi, lvl, ln;
    lvl = int'(fifo_level);
    lo  = use_dflt_thr ? D / 3 : int'(thr_low);        // R5
    hi  = use_dflt_thr ? (2 * D) / 3 : int'(thr_high);
    ln  = (burst_code == 2'd1) ? 128 / WB : (burst_code == 2'd2) ? 256 / WB : 0;
    if (rst) begin
      m_boost = 0; m_req = 0; m_len = 0; m_ur = 0;
    end else begin
      if (!panic_en || !disp_active) m_boost = 0;
      else if (lvl < lo) m_boost = 1;
      else if (lvl > hi) m_boost = 0;
      m_len = ln;
      m_req = (disp_active && ln != 0 && lvl + ln <= D) ? 1 : 0;
      if (fifo_rd && lvl == 0) m_ur = 1;
      else if (urun_clr) m_ur = 0;
    end
  endtask

  task automatic tick();
    model();
    @(posedge clk);
    @(negedge clk);
    check(btag, int'(prio_boost), m_boost);
    check("R7", int'(fetch_req), m_req);
    check("R6", int'(fetch_len), m_len);
    check("R8", int'(underrun), m_ur);
  endtask

  task automatic ramp();
    for (int l = D; l >= 0; l--) begin
      fifo_level = LW'(l);
      btag = (l < (use_dflt_thr ? D / 3 : int'(thr_low))) ? "R1" : (use_dflt_thr ? "R5" : "R2");
      tick();
    end
    for (int l = 0; l <= D; l++) begin
      fifo_level = LW'(l);
      btag = use_dflt_thr ? "R5" : "R2";
      tick();
    end
  endtask

  initial begin
    @(negedge clk);
    btag = "R9";
    tick();
    tick();
    check("R9", int'(prio_boost) + int'(fetch_req) + int'(underrun) + int'(fetch_len), 0);
    rst = 1'b0;

    // R1 and R2: hysteresis sweep with programmed watermarks
    panic_en = 1'b1; disp_active = 1'b1; thr_low = 7'd20; thr_high = 7'd40;
    burst_code = 2'd1;
    ramp();
    ramp();

    // R3: display idle forces off, and it stays off in the band afterwards
    fifo_level = 7'd5; btag = "R1"; tick();
    check("R1", int'(prio_boost), 1);
    disp_active = 1'b0; btag = "R3"; tick();
    check("R3", int'(prio_boost), 0);
    disp_active = 1'b1; fifo_level = 7'd30; tick(); tick();
    check("R3", int'(prio_boost), 0);

    // R4: enable cleared forces off even at a low level
    fifo_level = 7'd2; btag = "R1"; tick();
    panic_en = 1'b0; btag = "R4"; tick(); tick();
    check("R4", int'(prio_boost), 0);
    panic_en = 1'b1;

    // R5: default watermarks, with programmed inputs that conflict with them
    use_dflt_thr = 1'b1; thr_low = 7'd60; thr_high = 7'd63;
    ramp();
    use_dflt_thr = 1'b0;

    // R6 and R7: every code, every level, display idle and active
    btag = "R2";
    for (int a = 0; a < 2; a++) begin
      disp_active = a[0];
      for (int c = 0; c < 4; c++) begin
        burst_code = 2'(c);
        for (int l = 0; l <= D; l++) begin
          fifo_level = LW'(l);
          tick();
        end
      end
    end
    disp_active = 1'b1;

    // R8: underrun set, sticky, cleared, set wins over clear
    fifo_level = 7'd5; fifo_rd = 1'b1; tick();
    check("R8", int'(underrun), 0);
    fifo_level = 7'd0; tick();
    check("R8", int'(underrun), 1);
    fifo_rd = 1'b0; tick(); tick(); tick();
    check("R8", int'(underrun), 1);
    urun_clr = 1'b1; tick();
    check("R8", int'(underrun), 0);
    fifo_rd = 1'b1; tick();
    check("R8", int'(underrun), 1);
    fifo_rd = 1'b0; tick();
    check("R8", int'(underrun), 0);
    urun_clr = 1'b0; tick();

    // R9: reset in mid-operation clears all outputs
    fifo_rd = 1'b1; tick();
    fifo_rd = 1'b0; rst = 1'b1; btag = "R9"; tick();
    check("R9", int'(prio_boost) + int'(fetch_req) + int'(underrun) + int'(fetch_len), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule